// File: doc/BRIEF.md
# Sorter-Based Stochastic Average Pool

This block merges M stochastic bit streams into one stream whose density is the average of the inputs. Each clock it takes one column of M bits, one bit from each input stream, and produces one output bit. The output carries exactly one 1 for every M input ones seen since the stream was opened. No random-select multiplexer and no binary counter are involved. The current column is sorted by a bitonic network built from OR/AND compare-exchange cells. It is then merged with a registered, sorted M-bit feedback vector that holds the surplus ones not yet paid out.

The output bit is the M-th largest bit of the 2M-bit merged vector, so it is 1 exactly when at least M ones are held. The same bit selects the feedback through a 2:1 multiplexer. When it is 1, the top M bits are spent and the lower M bits are kept. When it is 0, the upper M bits, which hold every one present, are kept. The block only counts ones, so unipolar and bipolar streams are treated alike.

A small controller has two states. ST_IDLE is left on `start` (transition IDLE_TO_ACCUM). ST_ACCUM stays in place on every cycle (transition ACCUM_HOLD). A `start` while in ST_ACCUM restarts the stream (transition ACCUM_RESTART), which empties the feedback.

Top module: `avg_pool_sorter`

## Requirements
- R1: After reset the controller is in ST_IDLE and `out_valid` is 0. A column offered before the first `start` gives `out_valid` 0 and leaves no ones behind.
- R2: `start` (active high) opens a stream. A column with `in_valid` in the same cycle is judged against empty feedback, and `out_valid` rises in that same cycle because the output is combinational from the column.
- R3: On an accepted column, `out_bit` is 1 exactly when the held ones plus the ones in `in_col` reach M. `out_bit` is 0 whenever `out_valid` is 0.
- R4: After each accepted column the held ones equal all input ones since `start` minus M times the output ones, and they stay below M. Over a stream, the output ones equal floor(input ones / M).
- R5: A cycle with `in_valid` low produces no output and keeps the held ones unchanged for later columns.
- R6: A `start` in the middle of a stream discards the held ones. A `start` without `in_valid` only clears them.
- R7: A column of all ones always gives `out_bit` 1. A column of all zeros on empty feedback gives 0.
- R8: Bit j of `in_col` is the current bit of input stream j, and all M bits are equivalent. Both odd and even M give the same exact behaviour; odd M pads the sorter to the next power of two with zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Open or restart a stream; empties the feedback |
| in_valid | input | 1 | `in_col` holds a column this cycle |
| in_col | input | M | One bit from each input stream |
| out_bit | output | 1 | Averaged stream bit |
| out_valid | output | 1 | `out_bit` is meaningful this cycle |

## Verification
The bench builds two copies side by side, one with M = 4 and one with M = 5, and drives both with the same control sequence. The power-of-two width exercises the sorter and merger with no padding. The odd width forces zero padding inside both networks and an output tap that is not at a power-of-two boundary. Each copy's output is predicted every cycle from a held-ones model, and the stream totals are compared against floor(ones / M) at the end of each stream.

// File: rtl/avgp_pkg.sv
package avgp_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ACCUM = 1'b1
    } state_t;

    // Number of levels needed to pad a width up to a power of two
    function automatic int pad_levels(input int width);
        return (width > 1) ? $clog2(width) : 0;
    endfunction

endpackage

// File: rtl/avg_pool_sorter_sort.sv
// Bitonic sorter on single bits, descending: element 0 is the largest.
module avg_pool_sorter_sort #(
    parameter int W = 4
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int LG = avgp_pkg::pad_levels(W);
    localparam int P  = 1 << LG;
    localparam int NS = LG * (LG + 1) / 2;

    logic [NS:0][P-1:0] st;

    assign st[0] = P'(din);

    for (genvar a = 1; a <= LG; a++) begin : g_blk
        for (genvar b = a; b >= 1; b--) begin : g_stp
            localparam int S = a * (a - 1) / 2 + (a - b);
            localparam int K = 1 << a;
            localparam int J = 1 << (b - 1);
            for (genvar i = 0; i < P; i++) begin : g_el
                localparam int  L        = i ^ J;
                localparam bit  DESC     = ((i & K) == 0);
                localparam bit  TAKE_MAX = (DESC == (i < L));
                if (TAKE_MAX) begin : g_max
                    assign st[S+1][i] = st[S][i] | st[S][L];
                end else begin : g_min
                    assign st[S+1][i] = st[S][i] & st[S][L];
                end
            end
        end
    end

    assign dout = st[NS][W-1:0];

endmodule

// File: rtl/avg_pool_sorter_merge.sv
// Merges two descending W-bit vectors into one descending 2W-bit vector.
module avg_pool_sorter_merge #(
    parameter int W = 4
) (
    input  logic [W-1:0]   a_desc,
    input  logic [W-1:0]   b_desc,
    output logic [2*W-1:0] m_desc
);
    localparam int LG = avgp_pkg::pad_levels(W);
    localparam int P  = 1 << LG;
    localparam int Q  = 2 * P;

    logic [LG+1:0][Q-1:0] st;

    // Upper half: a as is (descending). Lower half: b reversed (ascending).
    for (genvar i = 0; i < P; i++) begin : g_load
        if (i < W) begin : g_a
            assign st[0][i] = a_desc[i];
        end else begin : g_apad
            assign st[0][i] = 1'b0;
        end
        if ((P - 1 - i) < W) begin : g_b
            assign st[0][P+i] = b_desc[P-1-i];
        end else begin : g_bpad
            assign st[0][P+i] = 1'b0;
        end
    end

    for (genvar t = 0; t <= LG; t++) begin : g_half
        localparam int J = P >> t;
        for (genvar i = 0; i < Q; i++) begin : g_el
            localparam int L = i ^ J;
            if (i < L) begin : g_max
                assign st[t+1][i] = st[t][i] | st[t][L];
            end else begin : g_min
                assign st[t+1][i] = st[t][i] & st[t][L];
            end
        end
    end

    assign m_desc = st[LG+1][2*W-1:0];

endmodule

// File: rtl/avg_pool_sorter.sv
module avg_pool_sorter #(
    parameter int M = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         in_valid,
    input  logic [M-1:0] in_col,
    output logic         out_bit,
    output logic         out_valid
);
    import avgp_pkg::*;

    state_t         state_q;
    state_t         state_d;
    logic [M-1:0]   fb_q;
    logic [M-1:0]   fb_d;
    logic [M-1:0]   fb_eff;
    logic [M-1:0]   col_sorted;
    logic [2*M-1:0] merged;
    logic           accept;
    logic           pay;

    // Feedback seen by this column: empty when a stream is (re)opened
    assign fb_eff = start ? '0 : fb_q;

    avg_pool_sorter_sort #(.W(M)) u_sort (
        .din  (in_col),
        .dout (col_sorted)
    );

    avg_pool_sorter_merge #(.W(M)) u_merge (
        .a_desc (col_sorted),
        .b_desc (fb_eff),
        .m_desc (merged)
    );

    // M-th largest merged bit: at least M ones are held
    assign pay = merged[M-1];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = start ? ST_ACCUM : ST_IDLE;
            ST_ACCUM: state_d = ST_ACCUM;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs and feedback selection
    always_comb begin
        accept    = 1'b0;
        fb_d      = fb_q;
        unique case (state_q)
            ST_IDLE:  accept = in_valid && start;
            ST_ACCUM: accept = in_valid;
            default:  accept = 1'b0;
        endcase
        out_valid = accept;
        out_bit   = accept & pay;
        if (accept) begin
            fb_d = pay ? merged[2*M-1:M] : merged[M-1:0];
        end else if (start) begin
            fb_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb_q <= '0;
        end else begin
            fb_q <= fb_d;
        end
    end

endmodule

// File: rtl/avg_pool_sorter_chk.sv
module avg_pool_sorter_chk #(
    parameter int M = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             in_valid,
    input logic [M-1:0]     in_col,
    input logic             out_bit,
    input logic             out_valid,
    input avgp_pkg::state_t state_q,
    input logic [M-1:0]     fb_q
);
    import avgp_pkg::*;

    // R1
    idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |-> !out_valid);

    // R3
    out_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_bit |-> out_valid);

    // R4
    fb_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fb_q) < M);

    // R4
    fb_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fb_q + 1'b1) & fb_q) == '0);

    // R5
    gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> !out_valid);

    // R5
    fb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !start) |=> $stable(fb_q));

    // R6
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !in_valid) |=> (fb_q == '0));

    // R7
    full_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (&in_col)) |-> out_bit);

endmodule

bind avg_pool_sorter avg_pool_sorter_chk #(.M(M)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .in_valid  (in_valid),
    .in_col    (in_col),
    .out_bit   (out_bit),
    .out_valid (out_valid),
    .state_q   (state_q),
    .fb_q      (fb_q)
);

// File: tb/avg_pool_sorter_bench.sv
module avg_pool_sorter_bench;
    localparam int ME = 4;
    localparam int MO = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          in_valid = 1'b0;
    logic [ME-1:0] col_e = '0;
    logic [MO-1:0] col_o = '0;
    logic          bit_e, val_e, bit_o, val_o;

    int total = 0;
    int fails = 0;

    // Bench model
    bit open_s = 0;
    int held_e = 0, held_o = 0;
    int in_e = 0, out_e = 0, in_o = 0, out_o = 0;

    always #4 clk = ~clk;

    avg_pool_sorter #(.M(ME)) u_avg_pool_sorter (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_col(col_e), .out_bit(bit_e), .out_valid(val_e)
    );

    avg_pool_sorter #(.M(MO)) u_avg_pool_sorter_odd (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_col(col_o), .out_bit(bit_o), .out_valid(val_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int pay_out(input int held, input int ones, input int m);
        return ((held + ones) >= m) ? 1 : 0;
    endfunction

    task automatic step(input bit st, input bit v, input logic [ME-1:0] ce,
                        input logic [MO-1:0] co, input string tag);
        bit acc;
        int ee, eo;
        @(negedge clk);
        start = st; in_valid = v; col_e = ce; col_o = co;
        #2;
        acc = v && (st || open_s);
        if (st) begin
            open_s = 1; held_e = 0; held_o = 0;
            in_e = 0; out_e = 0; in_o = 0; out_o = 0;
        end
        ee = 0; eo = 0;
        if (acc) begin
            ee = pay_out(held_e, $countones(ce), ME);
            eo = pay_out(held_o, $countones(co), MO);
            held_e = held_e + $countones(ce) - ee * ME;
            held_o = held_o + $countones(co) - eo * MO;
            in_e += $countones(ce); out_e += ee;
            in_o += $countones(co); out_o += eo;
        end
        check({tag, " valid M4"}, int'(val_e), int'(acc));
        check({tag, " bit M4"},   int'(bit_e), ee);
        check({tag, " valid M5"}, int'(val_o), int'(acc));
        check({tag, " bit M5"},   int'(bit_o), eo);
    endtask

    task automatic stream_end(input string tag);
        check({tag, " total M4"}, out_e, in_e / ME);
        check({tag, " total M5"}, out_o, in_o / MO);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset valid M4", int'(val_e), 0);
        check("R1 reset valid M5", int'(val_o), 0);
        rst_n = 1'b1;

        // R1: columns before any start are dropped
        step(0, 1, '1, '1, "R1 idle");
        step(0, 1, 4'b0111, 5'b01111, "R1 idle");

        // R2 + R7: open with a full column, judged on empty feedback
        step(1, 1, '1, '1, "R2 open");
        step(0, 1, '0, '0, "R7 zeros");
        step(0, 1, '0, '0, "R7 zeros");
        step(0, 1, '1, '1, "R7 ones");
        step(0, 1, '1, '1, "R7 ones");

        // R5: hold M-1 ones across a gap, then one more pays out
        step(0, 1, 4'b1011, 5'b11011, "R3 below");
        step(0, 0, '1, '1, "R5 gap");
        step(0, 0, '0, '0, "R5 gap");
        step(0, 1, 4'b0100, 5'b00100, "R5 kept");

        // R6: held ones discarded by a restart
        step(0, 1, 4'b1101, 5'b10111, "R6 fill");
        step(1, 1, 4'b0001, 5'b00001, "R6 restart");
        step(0, 1, 4'b0110, 5'b01110, "R6 fill");
        step(1, 0, '0, '0, "R6 clear");
        step(0, 1, 4'b0001, 5'b00001, "R6 cleared");
        stream_end("R4 directed");

        // R3/R4/R8: random dense stream
        step(1, 1, ME'($urandom), MO'($urandom), "R3 rand");
        for (int k = 1; k < 1024; k++) begin
            step(0, ($urandom % 10) != 0, ME'($urandom), MO'($urandom), "R3 rand");
        end
        stream_end("R4 dense");

        // R3/R4/R8: random sparse stream
        step(1, 1, ME'($urandom & $urandom), MO'($urandom & $urandom), "R8 sparse");
        for (int k = 1; k < 1024; k++) begin
            step(0, ($urandom % 4) != 0, ME'($urandom & $urandom),
                 MO'($urandom & $urandom), "R8 sparse");
        end
        stream_end("R4 sparse");

        step(0, 0, '0, '0, "R5 idle end");
        summary();
        $finish;
    end

endmodule